// File: doc/BRIEF.md
# Clock Parameter RAM Command Sequencer

This block runs the byte protocol of a battery-backed clock chip. A host sends one byte at a time. Each byte is a command, a second address byte or a data byte, depending on the transaction phase the block is in. The block keeps 256 bytes of parameter RAM, four seconds bytes, a write-protect register and a test register. For every byte it gives back one 9-bit result: a data byte, a "more bytes expected" code or a "transaction complete" code.

The command byte chooses the target. Short forms reach the seconds bytes, RAM locations 0x00 to 0x13, and the two control registers. An extended form splits an 8-bit RAM address across two bytes. A read returns its byte as soon as the address is known. A write waits for one more byte, and the write-protect register decides whether that byte is stored. Advancing the seconds counter in real time and carrying the bytes to and from the host belong to other blocks.

Top module: `rtc_pram_seq`

## Requirements
- R1: After reset the block is in the command phase. The write-protect register, all RAM bytes and all seconds bytes are 0x00, and out_valid_o is low.
- R2: Every cycle with in_valid_i high produces exactly one cycle of out_valid_o high on the next cycle. out_valid_o is low in every other cycle, and nothing changes state without in_valid_i.
- R3: Result encoding on out_result_o. 0x000 to 0x0FF is a data byte, 0x100 means more bytes are expected, and 0x101 means the transaction is complete.
- R4: A command with bits 6:4 = 000 targets seconds byte number bits 3:2.
- R5: A command with bits 6:4 = 010 targets RAM address 0x10 plus bits 3:2. A command with bit 6 set targets RAM address bits 5:2, which covers 0x00 to 0x0F.
- R6: A command with bits 6:4 = 001 is unrecognised. It returns 0x101 and the block stays in the command phase.
- R7: A command with bits 6:4 = 011 and bit 3 set is extended. Its bits 2:0 become RAM address bits 7:5. It returns 0x100 and waits for a second byte, as a read if command bit 7 is set and as a write if it is clear. A valid second byte supplies address bits 4:0 from its bits 6:2. For a read it returns the RAM byte and goes back to the command phase. For a write it returns 0x100 and waits for data.
- R8: A second address byte with any of bits 7, 1 or 0 set aborts the transaction. The block returns 0x101, goes back to the command phase and changes no storage.
- R9: A command with bits 6:4 = 011 and bit 3 clear targets the write-protect register if bit 2 is set, or the test register if bit 2 is clear. Reading either one returns 0x101 and no data.
- R10: In a short-form command, bit 7 set is a read and returns the addressed byte at once. Bit 7 clear returns 0x100 and waits for a data byte.
- R11: A data byte always returns 0x101 and ends in the command phase. Its effect depends on the target. The write-protect register is always loaded. The test register discards the byte. Any other write is dropped while write-protect bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | One-cycle strobe: in_byte_i holds a byte |
| in_byte_i | input | 8 | Command, address or data byte |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| out_result_o | output | 9 | Data byte, 0x100 or 0x101 |

## Verification
A wrong phase shows up at the ports on the very next strobe. The byte gets decoded as the wrong kind, so a read comes back as 0x100 or 0x101 instead of data, or a plain command gets swallowed as data. A wrong latched address or a broken write-protect gate does not show on the write itself, because a write always answers 0x101. It appears on the first later read of the affected byte, so the bench reads back each location it writes and predicts every result with a behavioural model.

// File: rtl/rtc_pram_pkg.sv
package rtc_pram_pkg;
  localparam int ADDR_W    = 8;
  localparam int RAM_DEPTH = 1 << ADDR_W;
  localparam int SEC_N     = 4;
  localparam int RES_W     = 9;

  localparam logic [RES_W-1:0] RES_PEND = 9'h100;
  localparam logic [RES_W-1:0] RES_DONE = 9'h101;

  typedef enum logic [1:0] {PH_CMD, PH_SB_RD, PH_SB_WR, PH_WDATA} phase_e;
  typedef enum logic [1:0] {TG_RAM, TG_SEC, TG_WP, TG_TST} tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [ADDR_W-1:0] addr;
    logic              ext;
    logic              bad;
  } dec_t;
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_pram_pkg::*;
(
  input  logic [7:0] cmd_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.tgt  = TG_RAM;
    unique casez (cmd_i[6:4])
      3'b000: begin
        dec_o.tgt  = TG_SEC;
        dec_o.addr = ADDR_W'(cmd_i[3:2]);
      end
      3'b001: dec_o.bad = 1'b1;
      3'b010: dec_o.addr = ADDR_W'(8'h10) | ADDR_W'(cmd_i[3:2]);
      3'b011: begin
        if (cmd_i[3]) begin
          dec_o.ext  = 1'b1;
          dec_o.addr = {cmd_i[2:0], 5'b0};
        end else begin
          dec_o.tgt = cmd_i[2] ? TG_WP : TG_TST;
        end
      end
      default: dec_o.addr = ADDR_W'(cmd_i[5:2]);
    endcase
  end
endmodule

// File: rtl/rtc_pram_store.sv
module rtc_pram_store
  import rtc_pram_pkg::*;
#(
  parameter int DEPTH = RAM_DEPTH,
  parameter int NSEC  = SEC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  tgt_e              wr_tgt_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  tgt_e              rd_tgt_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;

  logic [7:0] ram_q [DEPTH];
  logic [7:0] sec_q [NSEC];
  logic [7:0] wp_q;
  logic       wr_ok;

  // write-protect register bypasses its own gate
  assign wr_ok = we_i && !wp_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
    end else if (we_i && wr_tgt_i == TG_WP) begin
      wp_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ram_q[i] <= '0;
    end else if (wr_ok && wr_tgt_i == TG_RAM) begin
      ram_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSEC; i++) sec_q[i] <= '0;
    end else if (wr_ok && wr_tgt_i == TG_SEC) begin
      sec_q[wr_addr_i[SW-1:0]] <= wr_data_i;
    end
  end

  always_comb begin
    unique case (rd_tgt_i)
      TG_SEC:  rd_data_o = sec_q[rd_addr_i[SW-1:0]];
      TG_RAM:  rd_data_o = ram_q[rd_addr_i];
      default: rd_data_o = '0;
    endcase
  end

  // R11
  wp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_tgt_i == TG_WP) |=> wp_q == $past(wr_data_i));

  // R11
  wp_blocks_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_tgt_i == TG_RAM && wp_q[7]) |=> ram_q[$past(wr_addr_i)] == $past(ram_q[wr_addr_i]));
endmodule

// File: rtl/rtc_pram_seq.sv
module rtc_pram_seq
  import rtc_pram_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_byte_i,
  output logic             out_valid_o,
  output logic [RES_W-1:0] out_result_o
);
  phase_e            phase_q, phase_d;
  tgt_e              tgt_q, tgt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              vld_q;

  dec_t              dec;
  logic              sb_bad;
  logic [ADDR_W-1:0] sb_addr;
  logic              we;
  tgt_e              rd_tgt;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  rtc_cmd_decode u_dec (.cmd_i(in_byte_i), .dec_o(dec));

  assign sb_bad  = in_byte_i[7] | in_byte_i[1] | in_byte_i[0];
  assign sb_addr = {addr_q[7:5], in_byte_i[6:2]};

  always_comb begin
    phase_d = phase_q;
    tgt_d   = tgt_q;
    addr_d  = addr_q;
    res_d   = RES_PEND;
    we      = 1'b0;
    rd_tgt  = dec.tgt;
    rd_addr = dec.addr;
    unique case (phase_q)
      PH_CMD: begin
        if (dec.bad) begin
          res_d = RES_DONE;
        end else if (dec.ext) begin
          addr_d  = dec.addr;
          tgt_d   = TG_RAM;
          phase_d = in_byte_i[7] ? PH_SB_RD : PH_SB_WR;
        end else if (in_byte_i[7]) begin
          res_d = (dec.tgt == TG_WP || dec.tgt == TG_TST) ? RES_DONE : {1'b0, rd_data};
        end else begin
          tgt_d   = dec.tgt;
          addr_d  = dec.addr;
          phase_d = PH_WDATA;
        end
      end
      PH_SB_RD, PH_SB_WR: begin
        rd_tgt  = TG_RAM;
        rd_addr = sb_addr;
        if (sb_bad) begin
          res_d   = RES_DONE;
          phase_d = PH_CMD;
        end else if (phase_q == PH_SB_RD) begin
          res_d   = {1'b0, rd_data};
          phase_d = PH_CMD;
        end else begin
          addr_d  = sb_addr;
          phase_d = PH_WDATA;
        end
      end
      default: begin
        we      = in_valid_i;
        res_d   = RES_DONE;
        phase_d = PH_CMD;
      end
    endcase
  end

  rtc_pram_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wr_tgt_i  (tgt_q),
    .wr_addr_i (addr_q),
    .wr_data_i (in_byte_i),
    .rd_tgt_i  (rd_tgt),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      tgt_q   <= TG_RAM;
      addr_q  <= '0;
      res_q   <= RES_PEND;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        phase_q <= phase_d;
        tgt_q   <= tgt_d;
        addr_q  <= addr_d;
        res_q   <= res_d;
      end
    end
  end

  assign out_valid_o  = vld_q;
  assign out_result_o = res_q;

  // R2
  strobe_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R2
  no_spurious_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(phase_q));

  // R11
  data_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && phase_q == PH_WDATA) |=> (out_result_o == RES_DONE && phase_q == PH_CMD));

  // R8
  sb_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (phase_q == PH_SB_RD || phase_q == PH_SB_WR) && sb_bad)
      |=> (out_result_o == RES_DONE && phase_q == PH_CMD));

  // R9
  ctl_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && phase_q == PH_CMD && in_byte_i[7] && in_byte_i[6:3] == 4'b0110)
      |=> out_result_o == RES_DONE);

  // R6
  unrec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && phase_q == PH_CMD && in_byte_i[6:4] == 3'b001)
      |=> (out_result_o == RES_DONE && phase_q == PH_CMD));
endmodule

// File: tb/rtc_pram_seq_tb.sv
`timescale 1ns/1ps
module rtc_pram_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid;
  logic [8:0] out_result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int mram [256];
  int msec [4];
  int mwp, mph, maddr, mtgt;

  always #4 clk = ~clk;

  rtc_pram_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .out_valid_o(out_valid), .out_result_o(out_result)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // behavioural model: 0 cmd, 1 second byte read, 2 second byte write, 3 data
  // targets: 0 RAM, 1 seconds, 2 write-protect, 3 test
  function automatic int model(input int b);
    int r, ty;
    r = 256;
    ty = (b >> 4) & 7;
    if (mph == 0) begin
      if (ty == 1) r = 257;
      else if (ty == 3 && (b & 8) != 0) begin
        maddr = (b & 7) << 5;
        mph = ((b & 128) != 0) ? 1 : 2;
      end else begin
        if (ty == 0) begin mtgt = 1; maddr = (b >> 2) & 3; end
        else if (ty == 2) begin mtgt = 0; maddr = 16 + ((b >> 2) & 3); end
        else if (ty == 3) mtgt = ((b & 4) != 0) ? 2 : 3;
        else begin mtgt = 0; maddr = (b >> 2) & 15; end
        if ((b & 128) != 0) r = (mtgt >= 2) ? 257 : (mtgt == 1 ? msec[maddr] : mram[maddr]);
        else mph = 3;
      end
    end else if (mph == 1 || mph == 2) begin
      if ((b & 8'h83) != 0) begin r = 257; mph = 0; end
      else begin
        maddr = maddr | ((b >> 2) & 31);
        mtgt = 0;
        if (mph == 1) begin r = mram[maddr]; mph = 0; end
        else mph = 3;
      end
    end else begin
      if (mtgt == 2) mwp = b;
      else if (mtgt != 3 && (mwp & 128) == 0) begin
        if (mtgt == 1) msec[maddr] = b; else mram[maddr] = b;
      end
      r = 257;
      mph = 0;
    end
    return r;
  endfunction

  task automatic send(input int b, input string rq);
    int exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = 8'(b);
    exp = model(b);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R2", int'(out_valid), 1);
    check(out_result === 9'(exp), rq, int'(out_result), exp);
  endtask

  task automatic idle();
    @(negedge clk);
    check(out_valid === 1'b0, "R2", int'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mram[i] = 0;
    for (int i = 0; i < 4; i++) msec[i] = 0;
    mwp = 0; mph = 0; maddr = 0; mtgt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle();
    send(8'hC0 | (5 << 2), "R1");
    send(8'h80 | (2 << 2), "R1");
    // R4 seconds bytes
    for (int i = 0; i < 4; i++) begin
      send(i << 2, "R4"); send(8'hA0 + i, "R11");
    end
    for (int i = 0; i < 4; i++) send(8'h80 | (i << 2), "R4");
    idle();
    // R5 low RAM and 0x10..0x13
    send(8'h40 | (3 << 2), "R10"); send(8'h5A, "R11");
    send(8'hC0 | (3 << 2), "R5");
    send(8'h20 | (2 << 2), "R5"); send(8'h77, "R11");
    send(8'hA0 | (2 << 2), "R5");
    // R7 extended read of 0x12 and write/read of 0xE7
    send(8'hB8, "R7"); send(8'h12 << 2, "R7");
    send(8'h3F, "R7"); send(8'h07 << 2, "R7"); send(8'hC3, "R11");
    send(8'hBF, "R7"); send(8'h07 << 2, "R7");
    idle();
    // R8 bad second bytes
    send(8'hB8, "R7"); send(8'h49, "R8");
    send(8'hA8, "R8");
    send(8'h3F, "R7"); send(8'h80 | (8'h07 << 2), "R8");
    send(8'hBF, "R8"); send(8'h07 << 2, "R8");
    send(8'h38, "R7"); send(8'h01, "R8");
    send(8'h38, "R7"); send(8'h02, "R8");
    // R6 unrecognised
    send(8'h10, "R6"); send(8'h9C, "R6");
    send(8'hC0 | (3 << 2), "R6");
    // R9 control reads
    send(8'hB4, "R9"); send(8'hB0, "R9");
    // R11 test register write discarded, writes still allowed
    send(8'h30, "R9"); send(8'hFF, "R11");
    send(8'h40 | (1 << 2), "R10"); send(8'h11, "R11");
    send(8'hC0 | (1 << 2), "R11");
    idle();
    // R11 write protect on
    send(8'h34, "R9"); send(8'h80, "R11");
    send(8'h40 | (1 << 2), "R10"); send(8'h22, "R11");
    send(8'hC0 | (1 << 2), "R11");
    send(8'h04, "R10"); send(8'h99, "R11");
    send(8'h84, "R11");
    send(8'h3F, "R7"); send(8'h07 << 2, "R7"); send(8'h00, "R11");
    send(8'hBF, "R11"); send(8'h07 << 2, "R11");
    // R11 write protect register bypasses gate
    send(8'h34, "R11"); send(8'h00, "R11");
    send(8'h40 | (1 << 2), "R10"); send(8'h22, "R11");
    send(8'hC0 | (1 << 2), "R11");
    // R3 data 0xFF distinct from codes
    send(8'h40, "R10"); send(8'hFF, "R11");
    send(8'hC0, "R3");
    idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule